// File: doc/BRIEF.md
# Six-Device Transistor Metric Sorter

This combinational block evaluates six MOS transistors side by side. Each device is described by a width, a gate-source voltage and a drain-source voltage, all small unsigned integers. From its voltages each device is classed as cut off, triode or saturated. An integer square-law formula for that class then gives either its drain current or its transconductance, with a fixed threshold of 1 and division by 3 truncated toward zero.

The six results pass through a fixed compare-exchange network that arranges them in ascending order. A second control bit then selects the top or the bottom of that order as the single output. There is no clock, no handshake and no state: the output is a pure function of the inputs. The stream conventions of the surrounding fabric therefore do not apply, and a host holds the inputs steady for as long as it needs the result.

Top module: `mos_metric_sorter`

## Requirements
- R1: A device whose gate-source voltage is 0 or 1 contributes 0, whatever its width, drain-source voltage or the metric chosen.
- R2: With `metric_sel`=0 (current), a device with overdrive Vov = Vgs-1 > 0 and Vov <= Vds is saturated and contributes floor(W*Vov*Vov/3).
- R3: With `metric_sel`=0, a device with Vov > 0 and Vds < Vov is in triode and contributes floor(W*(2*Vov*Vds - Vds*Vds)/3).
- R4: With `metric_sel`=1 (transconductance), a saturated device contributes floor(2*W*Vov/3).
- R5: With `metric_sel`=1, a triode device contributes floor(2*W*Vds/3).
- R6: With `pick_max`=1 the output equals the largest of the six device results.
- R7: With `pick_max`=0 the output equals the smallest of the six device results, and ties among equal values give that same value.
- R8: A device of width 0 contributes 0 in either metric and either region, so it sets the minimum to 0.
- R9: The output follows any input change without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dev_w | input | 6x3 | Width of each device; element i belongs to device i |
| dev_vgs | input | 6x3 | Gate-source voltage of each device |
| dev_vds | input | 6x3 | Drain-source voltage of each device |
| metric_sel | input | 1 | 0 selects drain current, 1 selects transconductance |
| pick_max | input | 1 | 1 outputs the largest result, 0 the smallest |
| result | output | 8 | Selected result, unsigned |

## Verification
The hardest case to reach from the ports is the one where the chosen extreme comes from a single device in a particular region while the other five sit in other regions. This makes region classification and the sort order matter at the same time. Directed vectors build exactly this: one device is placed in triode or saturation with a known value, and the other five are pinned to cut-off, zero width or a dominating saturated value. Hand-computed results are compared. A long run of random vectors in both metrics and both selections then covers the operating space at random, with the expected value taken from an independent model in the bench.

// File: rtl/mos_sort_pkg.sv
package mos_sort_pkg;

  localparam int unsigned NUM_DEV = 6;
  localparam int unsigned NUM_CE  = 12;

  // Optimal 12-element, depth-5 sorting network for six inputs.
  // Each entry is one compare-exchange; low index receives the smaller value.
  localparam int CE_LO [NUM_CE] = '{0, 1, 2, 1, 3, 0, 2, 0, 2, 4, 1, 3};
  localparam int CE_HI [NUM_CE] = '{5, 3, 4, 2, 4, 3, 5, 1, 3, 5, 2, 4};

  typedef enum logic [1:0] {
    RGN_OFF    = 2'd0,
    RGN_TRIODE = 2'd1,
    RGN_SAT    = 2'd2
  } region_e;

endpackage

// File: rtl/mos_metric_unit.sv
module mos_metric_unit
  import mos_sort_pkg::*;
#(
  parameter int unsigned VW      = 3,
  parameter int unsigned RW      = 8,
  parameter int unsigned DIVISOR = 3
) (
  input  logic [VW-1:0] w,
  input  logic [VW-1:0] vgs,
  input  logic [VW-1:0] vds,
  input  logic          metric_sel,
  output region_e       region,
  output logic [RW-1:0] value
);

  localparam int unsigned PW = 3 * VW + 2;

  logic [VW-1:0] vov;
  logic [PW-1:0] num;
  logic [PW-1:0] quo;

  // Region decision from terminal voltages
  always_comb begin
    vov = '0;
    if (vgs <= VW'(1)) begin
      region = RGN_OFF;
    end else begin
      vov = vgs - VW'(1);
      region = (vov <= vds) ? RGN_SAT : RGN_TRIODE;
    end
  end

  // Numerator of the square-law formula for the region and metric
  always_comb begin
    unique case (region)
      RGN_SAT: begin
        if (metric_sel) num = PW'(2) * PW'(w) * PW'(vov);
        else            num = PW'(w) * PW'(vov) * PW'(vov);
      end
      RGN_TRIODE: begin
        if (metric_sel) num = PW'(2) * PW'(w) * PW'(vds);
        else            num = PW'(w) * ((PW'(2) * PW'(vov) * PW'(vds)) - (PW'(vds) * PW'(vds)));
      end
      default: num = '0;
    endcase
  end

  assign quo   = num / PW'(DIVISOR);
  assign value = quo[RW-1:0];

  always_comb begin
    // R2 R3: the quotient never exceeds the result width
    a_r2_fits: assert (quo < PW'(1 << RW));
    // R1: cut-off devices contribute nothing
    if (vgs <= VW'(1)) a_r1_cutoff_zero: assert (value == '0);
    // R8: zero-width devices contribute nothing
    if (w == '0) a_r8_zero_width: assert (value == '0);
  end

endmodule

// File: rtl/cmp_exch.sv
module cmp_exch #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] lo,
  output logic [DW-1:0] hi
);

  // Ties keep their positions, so the network is stable
  logic swap;
  assign swap = (a > b);
  assign lo   = swap ? b : a;
  assign hi   = swap ? a : b;

  always_comb begin
    a_r6_ordered: assert (lo <= hi);
  end

endmodule

// File: rtl/sort_net6.sv
module sort_net6
  import mos_sort_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [NUM_DEV-1:0][DW-1:0] din,
  output logic [NUM_DEV-1:0][DW-1:0] dout
);

  localparam int unsigned SW = DW + 3;

  genvar k;
  for (k = 0; k < NUM_CE; k++) begin : g_ce
    localparam int LO = CE_LO[k];
    localparam int HI = CE_HI[k];
    logic [NUM_DEV-1:0][DW-1:0] v_in;
    logic [NUM_DEV-1:0][DW-1:0] v_out;
    logic [DW-1:0] lo_w;
    logic [DW-1:0] hi_w;

    if (k == 0) begin : g_first
      assign v_in = din;
    end else begin : g_next
      assign v_in = g_ce[k-1].v_out;
    end

    cmp_exch #(.DW(DW)) u_ce (
      .a (v_in[LO]),
      .b (v_in[HI]),
      .lo(lo_w),
      .hi(hi_w)
    );

    always_comb begin
      v_out     = v_in;
      v_out[LO] = lo_w;
      v_out[HI] = hi_w;
    end
  end

  assign dout = g_ce[NUM_CE-1].v_out;

  logic [SW-1:0] sum_in;
  logic [SW-1:0] sum_out;
  always_comb begin
    sum_in  = '0;
    sum_out = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      sum_in  = sum_in + SW'(din[i]);
      sum_out = sum_out + SW'(dout[i]);
    end
    // R6 R7: the network only reorders values
    a_r7_sum_kept: assert (sum_in == sum_out);
    for (int i = 0; i < NUM_DEV - 1; i++) begin
      a_r6_ascending: assert (dout[i] <= dout[i+1]);
    end
  end

endmodule

// File: rtl/mos_metric_sorter.sv
module mos_metric_sorter
  import mos_sort_pkg::*;
#(
  parameter int unsigned VW = 3,
  parameter int unsigned RW = 8
) (
  input  logic [NUM_DEV-1:0][VW-1:0] dev_w,
  input  logic [NUM_DEV-1:0][VW-1:0] dev_vgs,
  input  logic [NUM_DEV-1:0][VW-1:0] dev_vds,
  input  logic                       metric_sel,
  input  logic                       pick_max,
  output logic [RW-1:0]              result
);

  logic [NUM_DEV-1:0][RW-1:0] metric;
  logic [NUM_DEV-1:0][RW-1:0] sorted;
  region_e                    region [NUM_DEV];

  genvar d;
  for (d = 0; d < NUM_DEV; d++) begin : g_dev
    mos_metric_unit #(.VW(VW), .RW(RW), .DIVISOR(3)) u_unit (
      .w         (dev_w[d]),
      .vgs       (dev_vgs[d]),
      .vds       (dev_vds[d]),
      .metric_sel(metric_sel),
      .region    (region[d]),
      .value     (metric[d])
    );
  end

  sort_net6 #(.DW(RW)) u_sort (
    .din (metric),
    .dout(sorted)
  );

  assign result = pick_max ? sorted[NUM_DEV-1] : sorted[0];

  always_comb begin
    for (int i = 0; i < NUM_DEV; i++) begin
      if (pick_max) a_r6_is_max: assert (result >= metric[i]);
      else          a_r7_is_min: assert (result <= metric[i]);
    end
  end

endmodule

// File: tb/sim_mos_metric_sorter.sv
module sim_mos_metric_sorter;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [5:0][2:0] dev_w;
  logic [5:0][2:0] dev_vgs;
  logic [5:0][2:0] dev_vds;
  logic            metric_sel;
  logic            pick_max;
  logic [7:0]      result;

  mos_metric_sorter u0 (
    .dev_w     (dev_w),
    .dev_vgs   (dev_vgs),
    .dev_vds   (dev_vds),
    .metric_sel(metric_sel),
    .pick_max  (pick_max),
    .result    (result)
  );

  int    n_run  = 0;
  int    n_fail = 0;
  bit    summary_done = 0;
  int    exp_q[$];
  string tag_q[$];

  task automatic check(string tag, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: result=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // Independent reference for one device
  function automatic int ref_dev(int w, int vgs, int vds, bit gm);
    int ov;
    if (vgs < 2) return 0;
    ov = vgs - 1;
    if (vds >= ov) return gm ? (2 * w * ov) / 3 : (w * ov * ov) / 3;
    return gm ? (2 * w * vds) / 3 : (w * vds * (2 * ov - vds)) / 3;
  endfunction

  function automatic int ref_all(logic [5:0][2:0] w, logic [5:0][2:0] g,
                                 logic [5:0][2:0] s, bit gm, bit mx);
    int best;
    best = ref_dev(int'(w[0]), int'(g[0]), int'(s[0]), gm);
    for (int i = 1; i < 6; i++) begin
      int v;
      v = ref_dev(int'(w[i]), int'(g[i]), int'(s[i]), gm);
      if (mx ? (v > best) : (v < best)) best = v;
    end
    return best;
  endfunction

  // Driver: apply one vector and push its expectation
  task automatic drive(logic [5:0][2:0] w, logic [5:0][2:0] g, logic [5:0][2:0] s,
                       bit gm, bit mx, int exp, string tag);
    @(posedge clk);
    dev_w = w; dev_vgs = g; dev_vds = s; metric_sel = gm; pick_max = mx;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare mid-cycle
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, int'(result), e);
    end
  end

  function automatic logic [5:0][2:0] fill(int v);
    logic [5:0][2:0] r;
    for (int i = 0; i < 6; i++) r[i] = 3'(v);
    return r;
  endfunction

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: result=%0d expected=done", result);
    finish_run();
  end

  initial begin
    logic [5:0][2:0] w, g, s;
    dev_w = '0; dev_vgs = '0; dev_vds = '0; metric_sel = 0; pick_max = 0;

    // R1: all-zero inputs give 0
    drive('0, '0, '0, 0, 1, 0, "R1 idle");
    // R1: every device cut off at Vgs=1
    drive(fill(7), fill(1), fill(7), 0, 1, 0, "R1 cutoff current");
    drive(fill(7), fill(1), fill(7), 1, 1, 0, "R1 cutoff gm");

    // R2: one saturated device, others cut off: 7*36/3 = 84
    w = fill(7); g = fill(0); s = fill(7); g[3] = 3'd7;
    drive(w, g, s, 0, 1, 84, "R2 sat current");
    // R2 boundary Vov == Vds: w=4, Vov=3, Vds=3 -> 36/3 = 12
    w = fill(4); g = fill(1); s = fill(3); g[0] = 3'd4;
    drive(w, g, s, 0, 1, 12, "R2 sat boundary");

    // R3: triode w=7 Vov=6 Vds=2 -> 7*20/3 = 46
    w = fill(7); g = fill(0); s = fill(2); g[5] = 3'd7;
    drive(w, g, s, 0, 1, 46, "R3 triode current");
    // R3: triode w=5 Vov=4 Vds=3 -> 5*15/3 = 25
    w = fill(5); g = fill(1); s = fill(3); g[2] = 3'd5;
    drive(w, g, s, 0, 1, 25, "R3 triode current 2");

    // R4: sat gm w=5 Vov=3 Vds=6 -> 30/3 = 10
    w = fill(5); g = fill(0); s = fill(6); g[1] = 3'd4;
    drive(w, g, s, 1, 1, 10, "R4 sat gm");

    // R5: triode gm w=7 Vov=6 Vds=1 -> 14/3 = 4
    w = fill(7); g = fill(0); s = fill(1); g[4] = 3'd7;
    drive(w, g, s, 1, 1, 4, "R5 triode gm");

    // R7: w=3, Vov=2, Vds {2,3,4,1,5,6} -> {4,4,4,3,4,4}, min 3
    w = fill(3); g = fill(3);
    s[0] = 3'd2; s[1] = 3'd3; s[2] = 3'd4; s[3] = 3'd1; s[4] = 3'd5; s[5] = 3'd6;
    drive(w, g, s, 0, 0, 3, "R7 min");
    drive(w, g, s, 0, 1, 4, "R6 max");

    // R7 ties: all six equal at 84
    drive(fill(7), fill(7), fill(7), 0, 0, 84, "R7 tie min");
    drive(fill(7), fill(7), fill(7), 0, 1, 84, "R6 tie max");

    // R8: one zero-width device among 84s sets min to 0
    w = fill(7); w[0] = 3'd0;
    drive(w, fill(7), fill(7), 0, 0, 0, "R8 zero width current");
    drive(w, fill(7), fill(2), 1, 0, 0, "R8 zero width gm");

    // Random sweep, expectation from the bench model
    for (int n = 0; n < 400; n++) begin
      bit gm, mx;
      for (int i = 0; i < 6; i++) begin
        w[i] = 3'($urandom_range(0, 7));
        g[i] = 3'($urandom_range(0, 7));
        s[i] = 3'($urandom_range(0, 7));
      end
      gm = 1'($urandom_range(0, 1));
      mx = 1'($urandom_range(0, 1));
      drive(w, g, s, gm, mx, ref_all(w, g, s, gm, mx), mx ? "R6 random" : "R7 random");
    end

    // R9: output follows inputs between clock edges
    @(negedge clk);
    @(posedge clk);
    #1;
    dev_w = fill(7); dev_vgs = fill(7); dev_vds = fill(7); metric_sel = 1; pick_max = 1;
    #0.5;
    check("R9 async follow", int'(result), 28);
    dev_vgs[2] = 3'd1;
    pick_max = 0;
    #0.3;
    check("R9 async follow min", int'(result), 0);

    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule